// File: doc/BRIEF.md
# Protective Trip Seal-In Logic

This block merges the trip requests of several protection functions into one trip output for a breaker. The request is the OR of five direct sources and one supervised source. The direct sources are phase time-overcurrent, ground time-overcurrent, frequency, manual panel trip and open-breaker command. The supervised source is phase instantaneous overcurrent, which is allowed to trip only while the reclose shot count is zero.

Once the trip is raised, it is sealed in. It cannot drop until a minimum duration has elapsed. That duration is counted in power-cycle strobes and is taken from a configuration input when the trip rises. After that, it drops only when no request is present and both overcurrent pickups have gone quiet.

A small shot counter steps once for every new trip, so the instantaneous element is blocked after the first trip of a reclose sequence. The counter stops at a parameter limit and is cleared by a reset input from the reclosing logic.

Top module: `trip_seal_top`

## Requirements
- R1: `trip_o` becomes 1 on the first rising clock edge at which any of `ph_toc_trip_i`, `gnd_toc_trip_i`, `freq_trip_i`, `manual_trip_i` or `open_cmd_i` is 1.
- R2: `ph_inst_oc_i` raises `trip_o` on the next edge only while `shot_o` is 0. With `shot_o` nonzero it has no effect on `trip_o`.
- R3: `shot_o` increases by one on each edge where `trip_o` goes from 0 to 1. It holds at `SHOT_MAX` (default 3). When `shot_rst_i` is 1 at an edge, `shot_o` is 0 after that edge, and this takes priority over a step in the same cycle.
- R4: While any trip request is present, `trip_o` stays 1.
- R5: When `trip_o` rises, the minimum-duration timer loads the value on `min_dur_i` (9 in normal use). `trip_o` remains 1 until that many `cyc_stb_i` strobes have been counted. A request that drops and returns while `trip_o` is still 1 does not reload the timer.
- R6: `trip_o` clears on the edge at which three conditions all hold: there is no request, the timer has expired, and both `ph_pickup_i` and `gnd_pickup_i` are 0. If either pickup is 1, the trip stays sealed in.
- R7: A synchronous reset `rst_i` clears `trip_o`, the timer and `shot_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_stb_i | input | 1 | One-clock strobe per power cycle |
| ph_toc_trip_i | input | 1 | Phase time-overcurrent trip |
| gnd_toc_trip_i | input | 1 | Ground time-overcurrent trip |
| freq_trip_i | input | 1 | Frequency element trip |
| manual_trip_i | input | 1 | Front-panel manual trip |
| ph_inst_oc_i | input | 1 | Phase instantaneous overcurrent |
| open_cmd_i | input | 1 | Open-breaker command |
| ph_pickup_i | input | 1 | Phase time-overcurrent pickup |
| gnd_pickup_i | input | 1 | Ground time-overcurrent pickup |
| shot_rst_i | input | 1 | Shot counter clear |
| min_dur_i | input | DUR_W | Minimum trip duration in power cycles |
| trip_o | output | 1 | Sealed-in trip output |
| shot_o | output | SHOT_W | Current reclose shot count |

## Verification
A request raises `trip_o` and steps `shot_o` on the first edge after it is driven, so the bench drives inputs at a falling edge and samples on the next falling edge. Release is due one edge after the last of three events: the Nth strobe edge, the pickup drop, or the request drop. Each check therefore samples `trip_o` twice: still 1 just after the Nth strobe edge, and 0 one clock later. Stimuli change only on falling edges, so every expected value applies to a known rising edge.

// File: rtl/trip_pkg.sv
package trip_pkg;

    // Trip sources presented to the request combiner.
    typedef struct packed {
        logic ph_toc;
        logic gnd_toc;
        logic freq;
        logic manual;
        logic open_cmd;
        logic inst_oc;
    } trip_src_t;

    // Sealed output state of the top level.
    typedef struct packed {
        logic trip;
    } seal_state_t;

endpackage

// File: rtl/trip_req_comb.sv
module trip_req_comb
    import trip_pkg::*;
(
    input  trip_src_t src_i,
    input  logic      shot_zero_i,
    output logic      direct_o,
    output logic      req_o
);

    always_comb begin
        direct_o = src_i.ph_toc | src_i.gnd_toc | src_i.freq
                 | src_i.manual | src_i.open_cmd;
        // Instantaneous element only counts on the first shot.
        req_o    = direct_o | (src_i.inst_oc & shot_zero_i);
    end

endmodule

// File: rtl/trip_min_timer.sv
module trip_min_timer #(
    parameter int unsigned DUR_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [DUR_W-1:0] load_val_i,
    input  logic             stb_i,
    output logic [DUR_W-1:0] count_o,
    output logic             expired_o
);

    typedef struct packed {
        logic [DUR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (stb_i && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign count_o   = tmr_q.cnt;
    assign expired_o = (tmr_q.cnt == '0);

endmodule

// File: rtl/trip_shot_ctr.sv
module trip_shot_ctr #(
    parameter  int unsigned SHOT_MAX = 3,
    localparam int unsigned SHOT_W   = $clog2(SHOT_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic              clr_i,
    output logic [SHOT_W-1:0] shot_o
);

    localparam logic [SHOT_W-1:0] SHOT_TOP = SHOT_W'(SHOT_MAX);

    typedef struct packed {
        logic [SHOT_W-1:0] shot;
    } shot_t;

    shot_t shot_d, shot_q;

    always_comb begin
        shot_d = shot_q;
        if (clr_i) begin
            shot_d.shot = '0;
        end else if (step_i && (shot_q.shot != SHOT_TOP)) begin
            shot_d.shot = shot_q.shot + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shot_q <= '0;
        end else begin
            shot_q <= shot_d;
        end
    end

    assign shot_o = shot_q.shot;

endmodule

// File: rtl/trip_seal_top.sv
module trip_seal_top
    import trip_pkg::*;
#(
    parameter  int unsigned DUR_W    = 8,
    parameter  int unsigned SHOT_MAX = 3,
    localparam int unsigned SHOT_W   = $clog2(SHOT_MAX + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cyc_stb_i,
    input  logic              ph_toc_trip_i,
    input  logic              gnd_toc_trip_i,
    input  logic              freq_trip_i,
    input  logic              manual_trip_i,
    input  logic              ph_inst_oc_i,
    input  logic              open_cmd_i,
    input  logic              ph_pickup_i,
    input  logic              gnd_pickup_i,
    input  logic              shot_rst_i,
    input  logic [DUR_W-1:0]  min_dur_i,
    output logic              trip_o,
    output logic [SHOT_W-1:0] shot_o
);

    trip_src_t         src;
    logic              direct_req;
    logic              any_req;
    logic              tmr_expired;
    logic [DUR_W-1:0]  tmr_cnt;
    logic              unlatch;
    logic              trip_rise;
    seal_state_t       seal_d, seal_q;

    assign src = '{ph_toc:   ph_toc_trip_i,
                   gnd_toc:  gnd_toc_trip_i,
                   freq:     freq_trip_i,
                   manual:   manual_trip_i,
                   open_cmd: open_cmd_i,
                   inst_oc:  ph_inst_oc_i};

    trip_req_comb u_req (
        .src_i       (src),
        .shot_zero_i (shot_o == '0),
        .direct_o    (direct_req),
        .req_o       (any_req)
    );

    always_comb begin
        unlatch   = ~ph_pickup_i & ~gnd_pickup_i;
        seal_d    = seal_q;
        // Sealed in: drop only with no request, expired timer and unlatch.
        seal_d.trip = any_req | (seal_q.trip & ~(tmr_expired & unlatch));
        trip_rise = seal_d.trip & ~seal_q.trip;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seal_q <= '0;
        end else begin
            seal_q <= seal_d;
        end
    end

    trip_min_timer #(.DUR_W(DUR_W)) u_tmr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (trip_rise),
        .load_val_i (min_dur_i),
        .stb_i      (cyc_stb_i),
        .count_o    (tmr_cnt),
        .expired_o  (tmr_expired)
    );

    trip_shot_ctr #(.SHOT_MAX(SHOT_MAX)) u_shot (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (trip_rise),
        .clr_i  (shot_rst_i),
        .shot_o (shot_o)
    );

    assign trip_o = seal_q.trip;

endmodule

// File: rtl/trip_seal_chk.sv
module trip_seal_chk #(
    parameter  int unsigned DUR_W    = 8,
    parameter  int unsigned SHOT_MAX = 3,
    localparam int unsigned SHOT_W   = $clog2(SHOT_MAX + 1)
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              ph_toc_trip_i,
    input logic              gnd_toc_trip_i,
    input logic              freq_trip_i,
    input logic              manual_trip_i,
    input logic              open_cmd_i,
    input logic              ph_pickup_i,
    input logic              gnd_pickup_i,
    input logic              shot_rst_i,
    input logic [DUR_W-1:0]  min_dur_i,
    input logic [DUR_W-1:0]  tmr_cnt,
    input logic              trip_o,
    input logic [SHOT_W-1:0] shot_o
);

    logic direct_any;
    assign direct_any = ph_toc_trip_i | gnd_toc_trip_i | freq_trip_i
                      | manual_trip_i | open_cmd_i;

    p_direct_trip_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        direct_any |=> trip_o);

    p_inst_blocked_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!trip_o && !direct_any && shot_o != '0) |=> !trip_o);

    p_shot_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!trip_o && !shot_rst_i && shot_o != SHOT_W'(SHOT_MAX))
        |=> (trip_o ? (shot_o == SHOT_W'($past(shot_o) + 1'b1))
                    : (shot_o == $past(shot_o))));

    p_shot_clear_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        shot_rst_i |=> (shot_o == '0));

    p_hold_req_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (trip_o && direct_any) |=> trip_o);

    p_timer_load_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!trip_o && direct_any) |=> (tmr_cnt == $past(min_dur_i)));

    p_min_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (trip_o && tmr_cnt != '0) |=> trip_o);

    p_unlatch_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (trip_o && (ph_pickup_i || gnd_pickup_i)) |=> trip_o);

    p_reset_r7: assert property (@(posedge clk_i)
        rst_i |=> (!trip_o && shot_o == '0 && tmr_cnt == '0));

endmodule

bind trip_seal_top trip_seal_chk #(.DUR_W(DUR_W), .SHOT_MAX(SHOT_MAX)) u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .ph_toc_trip_i  (ph_toc_trip_i),
    .gnd_toc_trip_i (gnd_toc_trip_i),
    .freq_trip_i    (freq_trip_i),
    .manual_trip_i  (manual_trip_i),
    .open_cmd_i     (open_cmd_i),
    .ph_pickup_i    (ph_pickup_i),
    .gnd_pickup_i   (gnd_pickup_i),
    .shot_rst_i     (shot_rst_i),
    .min_dur_i      (min_dur_i),
    .tmr_cnt        (tmr_cnt),
    .trip_o         (trip_o),
    .shot_o         (shot_o)
);

// File: tb/trip_seal_top_test.sv
module trip_seal_top_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cyc_stb;
    logic       ph_toc, gnd_toc, freq, manual, inst, open_cmd;
    logic       ph_pu, gnd_pu, shot_rst;
    logic [7:0] min_dur;
    logic       trip;
    logic [1:0] shot;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    trip_seal_top uut (
        .clk_i          (clk),
        .rst_i          (rst),
        .cyc_stb_i      (cyc_stb),
        .ph_toc_trip_i  (ph_toc),
        .gnd_toc_trip_i (gnd_toc),
        .freq_trip_i    (freq),
        .manual_trip_i  (manual),
        .ph_inst_oc_i   (inst),
        .open_cmd_i     (open_cmd),
        .ph_pickup_i    (ph_pu),
        .gnd_pickup_i   (gnd_pu),
        .shot_rst_i     (shot_rst),
        .min_dur_i      (min_dur),
        .trip_o         (trip),
        .shot_o         (shot)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int n);
        cyc_stb = 1'b1;
        tick(n);
        cyc_stb = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_src(input int i, input logic v);
        case (i)
            0: ph_toc   = v;
            1: gnd_toc  = v;
            2: freq     = v;
            3: manual   = v;
            default: open_cmd = v;
        endcase
    endtask

    task automatic clear_shot();
        shot_rst = 1'b1;
        tick(1);
        shot_rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7 trip after reset", int'(trip), 0);
        chk("R7 shot after reset", int'(shot), 0);
    endtask

    task automatic t_direct();
        for (int i = 0; i < 5; i++) begin
            set_src(i, 1'b1);
            tick(1);
            chk("R1 direct source trips", int'(trip), 1);
            chk("R3 shot steps and saturates", int'(shot), (i + 1 > 3) ? 3 : i + 1);
            set_src(i, 1'b0);
            strobe(9);
            chk("R5 held through nine strobes", int'(trip), 1);
            tick(1);
            chk("R6 released after expiry", int'(trip), 0);
        end
    endtask

    task automatic t_min_dur();
        clear_shot();
        manual = 1'b1;
        tick(1);
        manual = 1'b0;
        strobe(8);
        tick(5);
        chk("R5 still held after eight strobes", int'(trip), 1);
        strobe(1);
        chk("R5 held at ninth strobe edge", int'(trip), 1);
        tick(1);
        chk("R6 drop after ninth strobe", int'(trip), 0);
    endtask

    task automatic t_unlatch();
        ph_pu  = 1'b1;
        gnd_pu = 1'b1;
        manual = 1'b1;
        tick(1);
        manual = 1'b0;
        strobe(9);
        tick(3);
        chk("R6 both pickups hold trip", int'(trip), 1);
        ph_pu = 1'b0;
        tick(2);
        chk("R6 ground pickup holds trip", int'(trip), 1);
        gnd_pu = 1'b0;
        ph_pu  = 1'b1;
        tick(2);
        chk("R6 phase pickup holds trip", int'(trip), 1);
        ph_pu = 1'b0;
        tick(1);
        chk("R6 unlatch releases trip", int'(trip), 0);
    endtask

    task automatic t_hold_req();
        freq = 1'b1;
        tick(1);
        strobe(12);
        tick(2);
        chk("R4 request holds trip past timer", int'(trip), 1);
        freq = 1'b0;
        tick(1);
        chk("R4 release once request drops", int'(trip), 0);
    endtask

    task automatic t_no_retrigger();
        clear_shot();
        manual = 1'b1;
        tick(1);
        manual = 1'b0;
        strobe(5);
        freq = 1'b1;
        tick(1);
        freq = 1'b0;
        chk("R3 no step while trip high", int'(shot), 1);
        strobe(3);
        tick(2);
        chk("R5 held before original expiry", int'(trip), 1);
        strobe(1);
        tick(1);
        chk("R5 timer not reloaded", int'(trip), 0);
    endtask

    task automatic t_prog_dur();
        min_dur = 8'd3;
        gnd_toc = 1'b1;
        tick(1);
        gnd_toc = 1'b0;
        strobe(2);
        tick(2);
        chk("R5 short duration held", int'(trip), 1);
        strobe(1);
        tick(1);
        chk("R5 short duration release", int'(trip), 0);
        min_dur = 8'd9;
    endtask

    task automatic t_inst();
        clear_shot();
        chk("R3 shot cleared", int'(shot), 0);
        inst = 1'b1;
        tick(1);
        chk("R2 instantaneous trips at shot 0", int'(trip), 1);
        chk("R3 shot 0 to 1", int'(shot), 1);
        inst = 1'b0;
        strobe(9);
        tick(1);
        chk("R6 released", int'(trip), 0);
        inst = 1'b1;
        tick(3);
        chk("R2 instantaneous blocked at shot 1", int'(trip), 0);
        chk("R2 shot unchanged", int'(shot), 1);
        inst = 1'b0;
        shot_rst = 1'b1;
        manual   = 1'b1;
        tick(1);
        shot_rst = 1'b0;
        manual   = 1'b0;
        chk("R3 clear beats step", int'(shot), 0);
        strobe(9);
        tick(1);
        inst = 1'b1;
        tick(1);
        chk("R2 instantaneous after clear", int'(trip), 1);
        inst = 1'b0;
        strobe(9);
        tick(1);
    endtask

    task automatic t_sync_reset();
        open_cmd = 1'b1;
        tick(1);
        open_cmd = 1'b0;
        chk("R1 open command trips", int'(trip), 1);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R7 reset clears trip", int'(trip), 0);
        chk("R7 reset clears shot", int'(shot), 0);
        tick(3);
        chk("R7 timer cleared, no trip", int'(trip), 0);
    endtask

    initial begin
        rst = 1'b1;
        cyc_stb = 1'b0;
        ph_toc = 1'b0; gnd_toc = 1'b0; freq = 1'b0; manual = 1'b0;
        inst = 1'b0; open_cmd = 1'b0; ph_pu = 1'b0; gnd_pu = 1'b0;
        shot_rst = 1'b0;
        min_dur = 8'd9;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_direct();
        t_min_dur();
        t_unlatch();
        t_hold_req();
        t_no_retrigger();
        t_prog_dur();
        t_inst();
        t_sync_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule